// File: doc/BRIEF.md
# Keyboard Matrix Scanner Encoder

This block reads a key matrix of six rows by sixteen columns, one row per clock, each time a frame-start strobe arrives while it is idle. Every pressed position maps to an 8-bit code. Four code values are reserved for modifier keys: caps lock, shift, super-shift and control. These codes are never reported as keys. Instead, each one sets its own bit in a status byte whose upper nibble is fixed at binary 1000.

During the scan, any pressed ordinary position replaces the working key code. The last one in scan order therefore wins. Rows go from 0 to 5 and, inside a row, columns go from bit 0 up to bit 15. When the scan finishes with a nonzero working code, the code and the status are latched and a receive-ready flag is raised. The block also keeps a small count of bytes handed to the reader, and a latch clears that count. A reader acknowledge clears the ready flag and advances the count.

The controller has three states:
- `ST_IDLE` waits for a strobe.
- `ST_SCAN` presents one row index per cycle.
- `ST_DONE` lasts one cycle, raises the done pulse and commits the result.

Its transitions are:
- IDLE→SCAN on an accepted strobe.
- SCAN→SCAN while the row index is below the last row.
- SCAN→DONE after the last row.
- DONE→IDLE always.

Top module: `kbd_matrix_encoder`

## Requirements
- R1: After reset the key code is 0x00, the status is 0x80, the ready flag and the sent count are 0, and the controller is idle with row index 0.
- R2: A frame-start strobe seen while idle starts a scan. The row index is 0 in the first cycle after the accepting edge and rises by one per cycle up to 5. The done pulse is high for exactly the one cycle after row 5, and the latched outputs change on the edge that ends that cycle.
- R3: Position (row r, column c) carries code 16*r + c + 1, with the following exceptions. (1,12) is caps lock 0xFF, (2,9) is shift 0xFE, (3,6) is super-shift 0xFD and (3,7) is control 0xFC. Positions (5,13), (5,14) and (5,15) carry code 0x00.
- R4: Status bit 0 is set by shift, bit 1 by caps lock, bit 2 by control and bit 3 by super-shift. A modifier held anywhere in the scan sets its bit, and the bits start cleared for every scan.
- R5: Every pressed non-modifier position overwrites the working code, including the 0x00 positions. The code kept is that of the last such position in scan order.
- R6: A scan that ends with working code 0x00 latches nothing. This covers no key held, modifiers alone, and a 0x00 position last in order. Code, status, ready and sent count keep their values.
- R7: A scan that ends with a nonzero code latches code and status, sets the ready flag and clears the sent count.
- R8: Read acknowledge clears the ready flag and increments the sent count, which saturates at 3. A latch in the same cycle takes precedence and leaves the flag set with count 0.
- R9: A frame-start strobe while a scan is running or finishing is ignored and starts no second scan.
- R10: The upper nibble of the status output is always 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Request to scan the matrix once |
| row_bits | input | 16 | Pressed columns of the selected row, bit c = column c |
| rd_ack | input | 1 | Reader has taken the result |
| row_idx | output | 3 | Row currently selected for reading |
| scan_busy | output | 1 | Controller is not idle |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| key_code | output | 8 | Latched key code |
| key_status | output | 8 | Latched modifier status byte |
| rx_ready | output | 1 | A latched result is waiting for the reader |
| sent_count | output | 2 | Acknowledges since the last latch, saturating |

## Verification
Single keys at rows 0 and 5 check the code mapping and the row walk. Two ordinary keys in different rows, and two in the same row, show that scan order picks the winner. Scans with modifiers alone, and a scan whose last key is a zero-code position, show that nothing is latched. A mixed scan shows that modifier bits gather beside a key code. Sparse random matrices with a fixed seed, some with forced modifiers, are compared with a bench model of the table. Strobes during a scan, and acknowledges alone or coinciding with the done pulse, separate the controller's ignore rule from the precedence of latching over clearing.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    localparam int KB_ROWS = 6;
    localparam int KB_COLS = 16;

    localparam logic [7:0] CODE_CAPS  = 8'hFF;
    localparam logic [7:0] CODE_SHIFT = 8'hFE;
    localparam logic [7:0] CODE_SUPER = 8'hFD;
    localparam logic [7:0] CODE_CTRL  = 8'hFC;
    localparam logic [7:0] CODE_NONE  = 8'h00;

    localparam logic [3:0] STATUS_BASE = 4'h8;

    // modifier bit positions inside the status byte
    localparam int MOD_SHIFT_BIT = 0;
    localparam int MOD_CAPS_BIT  = 1;
    localparam int MOD_CTRL_BIT  = 2;
    localparam int MOD_SUPER_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;

    // Code carried by matrix position (r, c)
    function automatic logic [7:0] pos_code(input int r, input int c);
        if (r == 1 && c == 12)      return CODE_CAPS;
        else if (r == 2 && c == 9)  return CODE_SHIFT;
        else if (r == 3 && c == 6)  return CODE_SUPER;
        else if (r == 3 && c == 7)  return CODE_CTRL;
        else if (r == 5 && c >= 13) return CODE_NONE;
        else                        return 8'((r * KB_COLS) + c + 1);
    endfunction

endpackage

// File: rtl/kbd_row_decode.sv
module kbd_row_decode
    import kbd_scan_pkg::*;
#(
    parameter int COLS = KB_COLS,
    parameter int RW   = 3
) (
    input  logic [RW-1:0]   row,
    input  logic [COLS-1:0] bits,
    output logic            hit,
    output logic [7:0]      code,
    output logic [3:0]      mods
);

    logic [7:0] col_code [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_comb col_code[c] = pos_code(int'(row), c);
    end

    always_comb begin
        hit  = 1'b0;
        code = CODE_NONE;
        mods = '0;
        for (int c = 0; c < COLS; c++) begin
            if (bits[c]) begin
                case (col_code[c])
                    CODE_SHIFT: mods[MOD_SHIFT_BIT] = 1'b1;
                    CODE_CAPS:  mods[MOD_CAPS_BIT]  = 1'b1;
                    CODE_CTRL:  mods[MOD_CTRL_BIT]  = 1'b1;
                    CODE_SUPER: mods[MOD_SUPER_BIT] = 1'b1;
                    default: begin
                        hit  = 1'b1;
                        code = col_code[c];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/kbd_scan_fsm.sv
module kbd_scan_fsm
    import kbd_scan_pkg::*;
#(
    parameter int ROWS = KB_ROWS,
    parameter int RW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [RW-1:0] row_idx,
    output logic          start_ack,
    output logic          step,
    output logic          done,
    output logic          busy
);

    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    scan_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (frame_start) state_nx = ST_SCAN;
            ST_SCAN: if (row_idx == LAST_ROW) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx <= '0;
        end else if (state == ST_SCAN && row_idx != LAST_ROW) begin
            row_idx <= row_idx + RW'(1);
        end else begin
            row_idx <= '0;
        end
    end

    always_comb begin
        start_ack = 1'b0;
        step      = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy      = 1'b0;
                start_ack = frame_start;
            end
            ST_SCAN: step = 1'b1;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/kbd_result_latch.sv
module kbd_result_latch
    import kbd_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic       row_hit,
    input  logic [7:0] row_code,
    input  logic [3:0] row_mods,
    input  logic       commit,
    input  logic       rd_ack,
    output logic [7:0] key_code,
    output logic [7:0] key_status,
    output logic       rx_ready,
    output logic [1:0] sent_count
);

    logic [7:0] work_code;
    logic [3:0] work_mods;
    logic       take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_code <= CODE_NONE;
            work_mods <= '0;
        end else if (clear) begin
            work_code <= CODE_NONE;
            work_mods <= '0;
        end else if (step) begin
            if (row_hit) work_code <= row_code;
            work_mods <= work_mods | row_mods;
        end
    end

    assign take = commit && (work_code != CODE_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_code   <= CODE_NONE;
            key_status <= {STATUS_BASE, 4'h0};
            rx_ready   <= 1'b0;
            sent_count <= '0;
        end else if (take) begin
            key_code   <= work_code;
            key_status <= {STATUS_BASE, work_mods};
            rx_ready   <= 1'b1;
            sent_count <= '0;
        end else if (rd_ack) begin
            rx_ready <= 1'b0;
            if (sent_count != 2'd3) sent_count <= sent_count + 2'd1;
        end
    end

endmodule

// File: rtl/kbd_matrix_encoder.sv
module kbd_matrix_encoder
    import kbd_scan_pkg::*;
#(
    parameter int ROWS = KB_ROWS,
    parameter int COLS = KB_COLS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic [COLS-1:0]           row_bits,
    input  logic                      rd_ack,
    output logic [$clog2(ROWS)-1:0]   row_idx,
    output logic                      scan_busy,
    output logic                      scan_done,
    output logic [7:0]                key_code,
    output logic [7:0]                key_status,
    output logic                      rx_ready,
    output logic [1:0]                sent_count
);

    localparam int RW = $clog2(ROWS);

    logic       start_ack, step;
    logic       row_hit;
    logic [7:0] row_code;
    logic [3:0] row_mods;

    kbd_scan_fsm #(.ROWS(ROWS), .RW(RW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .row_idx(row_idx), .start_ack(start_ack), .step(step),
        .done(scan_done), .busy(scan_busy)
    );

    kbd_row_decode #(.COLS(COLS), .RW(RW)) u_dec (
        .row(row_idx), .bits(row_bits),
        .hit(row_hit), .code(row_code), .mods(row_mods)
    );

    kbd_result_latch u_lat (
        .clk(clk), .rst_n(rst_n), .clear(start_ack), .step(step),
        .row_hit(row_hit), .row_code(row_code), .row_mods(row_mods),
        .commit(scan_done), .rd_ack(rd_ack),
        .key_code(key_code), .key_status(key_status),
        .rx_ready(rx_ready), .sent_count(sent_count)
    );

endmodule

// File: rtl/kbd_encoder_checker.sv
module kbd_encoder_checker #(
    parameter int RW   = 3,
    parameter int ROWS = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          rd_ack,
    input logic [RW-1:0] row_idx,
    input logic          scan_busy,
    input logic          scan_done,
    input logic [7:0]    key_code,
    input logic [7:0]    key_status,
    input logic          rx_ready,
    input logic [1:0]    sent_count
);

    // R2: the done pulse lasts a single cycle
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R2: done follows the last row
    p_done_after_last_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_done) |-> $past(row_idx) == RW'(ROWS - 1));

    // R10: fixed upper nibble of the status
    p_status_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        key_status[7:4] == 4'h8);

    // R6 / R7: a ready result always carries a nonzero code
    p_ready_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> key_code != 8'h00);

    // R8: acknowledge without a commit clears ready
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !scan_done) |=> !rx_ready);

    // R6: outputs move only on a commit
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done |=> $stable(key_code) && $stable(key_status));

    // R9: an idle controller leaves idle only on a strobe
    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_busy && !frame_start) |=> !scan_busy);

    // R7: a fresh commit resets the sent count
    p_sent_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> sent_count == 2'd0);

endmodule

bind kbd_matrix_encoder kbd_encoder_checker #(.RW($clog2(ROWS)), .ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rd_ack(rd_ack),
    .row_idx(row_idx), .scan_busy(scan_busy), .scan_done(scan_done),
    .key_code(key_code), .key_status(key_status), .rx_ready(rx_ready),
    .sent_count(sent_count)
);

// File: tb/sim_kbd_matrix_encoder.sv
module sim_kbd_matrix_encoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        rd_ack = 1'b0;
    logic [15:0] row_bits;
    logic [2:0]  row_idx;
    logic        scan_busy, scan_done, rx_ready;
    logic [7:0]  key_code, key_status;
    logic [1:0]  sent_count;

    logic [15:0] mat [6];

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_code = 8'h00;
    logic [7:0] exp_stat = 8'h80;
    logic       exp_rdy  = 1'b0;
    logic [1:0] exp_sent = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign row_bits = (row_idx < 3'd6) ? mat[row_idx] : 16'h0;

    kbd_matrix_encoder u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_bits(row_bits),
        .rd_ack(rd_ack), .row_idx(row_idx), .scan_busy(scan_busy),
        .scan_done(scan_done), .key_code(key_code), .key_status(key_status),
        .rx_ready(rx_ready), .sent_count(sent_count)
    );

    function automatic logic [7:0] tb_code(input int r, input int c);
        if (r == 5 && c > 12) return 8'h00;
        if (r == 1 && c == 12) return 8'hFF;
        if (r == 2 && c == 9)  return 8'hFE;
        if (r == 3 && c == 6)  return 8'hFD;
        if (r == 3 && c == 7)  return 8'hFC;
        return 8'(r * 16 + c + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mat();
        for (int r = 0; r < 6; r++) mat[r] = 16'h0;
    endtask

    task automatic model_scan(output logic [7:0] code, output logic [3:0] mods);
        code = 8'h00;
        mods = 4'h0;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 16; c++)
                if (mat[r][c]) begin
                    logic [7:0] k;
                    k = tb_code(r, c);
                    if (k == 8'hFE)      mods[0] = 1'b1;
                    else if (k == 8'hFF) mods[1] = 1'b1;
                    else if (k == 8'hFC) mods[2] = 1'b1;
                    else if (k == 8'hFD) mods[3] = 1'b1;
                    else                 code = k;
                end
    endtask

    task automatic check_outputs(input string req);
        chk(key_code == exp_code, req, "key_code", 32'(key_code), 32'(exp_code));
        chk(key_status == exp_stat, req, "key_status", 32'(key_status), 32'(exp_stat));
        chk(rx_ready == exp_rdy, req, "rx_ready", 32'(rx_ready), 32'(exp_rdy));
        chk(sent_count == exp_sent, req, "sent_count", 32'(sent_count), 32'(exp_sent));
    endtask

    task automatic do_scan(input bit ack_at_done, input bit mid_start, input string req);
        logic [7:0] ec;
        logic [3:0] em;
        bit seq_ok;
        model_scan(ec, em);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        seq_ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (int'(row_idx) != k || scan_done || !scan_busy) seq_ok = 1'b0;
            frame_start = mid_start && (k == 2 || k == 5);
            @(negedge clk);
        end
        frame_start = 1'b0;
        chk(seq_ok, "R2", "row walk 0..5", 32'(row_idx), 32'd0);
        chk(scan_done == 1'b1, "R2", "done pulse", 32'(scan_done), 32'd1);
        rd_ack = ack_at_done;
        @(negedge clk) rd_ack = 1'b0;
        if (ec != 8'h00) begin
            exp_code = ec;
            exp_stat = {4'h8, em};
            exp_rdy  = 1'b1;
            exp_sent = 2'd0;
        end else if (ack_at_done) begin
            exp_rdy = 1'b0;
            if (exp_sent != 2'd3) exp_sent = exp_sent + 2'd1;
        end
        check_outputs(req);
        chk(scan_done == 1'b0, "R2", "done ended", 32'(scan_done), 32'd0);
        if (mid_start) begin
            repeat (3) @(negedge clk);
            chk(scan_busy == 1'b0, "R9", "no second scan", 32'(scan_busy), 32'd0);
        end
    endtask

    task automatic ack_once(input string req);
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        exp_rdy = 1'b0;
        if (exp_sent != 2'd3) exp_sent = exp_sent + 2'd1;
        check_outputs(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_mat();
        repeat (3) @(negedge clk);
        // R1 reset state
        check_outputs("R1");
        chk(scan_busy == 1'b0 && row_idx == 3'd0, "R1", "idle", 32'(scan_busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 empty matrix latches nothing
        do_scan(1'b0, 1'b0, "R6");
        // R3 single key row 0 col 0 -> 0x01
        mat[0][0] = 1'b1;
        do_scan(1'b0, 1'b0, "R3");
        // R8 ack clears ready, counts, saturates
        ack_once("R8");
        ack_once("R8");
        ack_once("R8");
        ack_once("R8");
        // R3 last ordinary position of row 5
        clear_mat(); mat[5][12] = 1'b1;
        do_scan(1'b0, 1'b0, "R3");
        // R5 later row wins
        clear_mat(); mat[0][3] = 1'b1; mat[4][2] = 1'b1;
        do_scan(1'b0, 1'b0, "R5");
        // R5 higher column wins in one row
        clear_mat(); mat[2][1] = 1'b1; mat[2][14] = 1'b1;
        do_scan(1'b0, 1'b0, "R5");
        // R6 modifiers only: no latch
        clear_mat(); mat[1][12] = 1'b1; mat[2][9] = 1'b1; mat[3][6] = 1'b1; mat[3][7] = 1'b1;
        do_scan(1'b0, 1'b0, "R6");
        // R4 all modifiers plus a key
        mat[4][4] = 1'b1;
        do_scan(1'b0, 1'b0, "R4");
        // R4 status bits restart each scan: shift only
        clear_mat(); mat[2][9] = 1'b1; mat[0][7] = 1'b1;
        do_scan(1'b0, 1'b0, "R4");
        // R5/R6 zero-code position last in order cancels the key
        clear_mat(); mat[1][1] = 1'b1; mat[5][14] = 1'b1;
        do_scan(1'b0, 1'b0, "R5");
        // R8 ack during done with a latch: latch wins
        clear_mat(); mat[3][0] = 1'b1;
        do_scan(1'b1, 1'b0, "R8");
        // R8 ack during done with no latch: clears
        clear_mat();
        do_scan(1'b1, 1'b0, "R8");
        // R9 strobes during a scan are ignored
        clear_mat(); mat[2][2] = 1'b1;
        do_scan(1'b0, 1'b1, "R9");

        // random scans (R3/R4/R5/R7)
        for (int n = 0; n < 40; n++) begin
            for (int r = 0; r < 6; r++)
                mat[r] = 16'($urandom & $urandom & $urandom & $urandom);
            if (($urandom % 3) == 0) mat[3][7] = 1'b1;
            if (($urandom % 3) == 0) mat[1][12] = 1'b1;
            do_scan(($urandom % 4) == 0, 1'b0, "R7");
            if (($urandom % 2) == 0) ack_once("R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule